// File: doc/BRIEF.md
# Counter Clock and Gate Router

This block sits in front of a bank of 16-bit timer-counter channels and decides, for every channel, what makes it count and what lets it count. Channels come in groups of three. Each channel holds a 3-bit clock-select code and a 3-bit gate-select code, both written and read over a small register bus. The block turns the selected clock source into a one-cycle clock-enable pulse on the system clock. It turns the selected gate source into a gate level. It also drives a direction control for the channel's CLK and GAT pins, so that a pin that is not used as an input can be driven as an output.

Clock sources are the channel's own CLK pin, five decade timebases, the output of the preceding channel, and an external clock pin shared by the group. Gate sources are constant enable, constant disable, the channel's own GAT pin, and the inverted output of the channel two places back. The timebases come from one 10 MHz tick input, which a chain of divide-by-ten stages scales down to 1 kHz. Groups are linked in a ring, so the first group's channel 0 follows the last group's channel 2.

The counting engines are outside this block. Their OUT signals arrive as inputs, synchronous to the system clock. Pin inputs are asynchronous and pass through a two-stage synchroniser before use.

Top module: `ctr_route`

## Requirements
- R1: After reset every clock code reads 0 and every gate code reads 2, so every clkPinOe and gatPinOe bit is 0 and all pins are inputs.
- R2: A write to address 2*ch (clock) or 2*ch+1 (gate) stores the low 3 bits of the data for channel ch, and a read at the same address returns them exactly, reserved gate codes 4 to 7 included. Addresses whose channel number is not below the channel count are ignored on write and read as 0.
- R3: clkPinOe of a channel is 1 whenever its clock code is not 0. gatPinOe is 1 whenever its gate code is not 2. Each changes in the cycle after the write.
- R4: Clock code 0: each rising edge on the channel's CLK pin gives one clkEn pulse, two cycles after the edge is first sampled.
- R5: Clock codes 1, 2, 3, 4 and 5 give one clkEn pulse per 1, 10, 100, 1000 and 10000 tbTick cycles, counted from reset.
- R6: Clock code 6: each rising edge of the previous channel's OUT gives one clkEn pulse in the same cycle. The previous channel is ch-1 in the group, and for ch 0 it is channel 2 of the preceding group, with the last group preceding the first.
- R7: Clock code 7: each rising edge on the group's shared external clock pin gives one clkEn pulse on every channel of that group that selects it, and none on other groups.
- R8: Gate code 0 gives gateLvl 1. Gate code 1 and the reserved codes 4 to 7 give gateLvl 0, whatever the GAT pin does.
- R9: Gate code 2: gateLvl follows the GAT pin through two sampling stages, so a change is seen in gateLvl after the second clock edge.
- R10: Gate code 3: gateLvl is the inverse of the OUT of channel 0 of the same group for ch 2, and of channel n+1 of the preceding group for ch n = 0 or 1, in the same cycle.
- R11: A CLK pin held high for many cycles gives exactly one clkEn pulse. Pin events never last two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tbTick | input | 1 | 10 MHz timebase tick, one cycle wide |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W (4) | Write address: channel in the upper bits, bit 0 selects gate (1) or clock (0) |
| wrData | input | 3 | Code to write |
| rdAddr | input | ADDR_W (4) | Read address, same layout as wrAddr |
| rdData | output | 3 | Code stored at rdAddr, combinational |
| clkPin | input | NCH (6) | Per-channel CLK pin input, asynchronous |
| gatPin | input | NCH (6) | Per-channel GAT pin input, asynchronous |
| grpClk | input | NUM_GROUPS (2) | Shared external clock pin for each group, asynchronous |
| ctrOut | input | NCH (6) | OUT of each counting engine, synchronous |
| clkEn | output | NCH (6) | Per-channel count enable pulse |
| gateLvl | output | NCH (6) | Per-channel gate level |
| clkPinOe | output | NCH (6) | 1 drives the channel's CLK pin as an output |
| gatPinOe | output | NCH (6) | 1 drives the channel's GAT pin as an output |

## Verification
The hardest cases to reach are the slowest timebase and the ring wrap-around. A single 1 kHz pulse needs ten thousand ticks with every decade counter aligned. The bench holds tbTick high for exactly ten thousand cycles from the reset state, with codes 1 to 5 spread over five channels, and compares each channel's pulse count. For the ring, the bench programs channel 0 of the first group and channel 0 of the second to follow their predecessors, and gives the inverted-output gate to channels 0, 2 and 3. It then raises single OUT lines one at a time, so that a link to the wrong neighbour shows up as a pulse or gate level on the wrong channel.

// File: rtl/ctr_route_pkg.sv
package ctr_route_pkg;

  localparam int CODE_W    = 3;
  localparam int TB_STAGES = 5;
  localparam int CH_IDX_W  = 8;
  localparam int GRP_SIZE  = 3;

  typedef logic [CODE_W-1:0] code_t;

  // clock-select encodings
  localparam code_t CLK_PIN  = 3'd0;
  localparam code_t CLK_PREV = 3'd6;
  localparam code_t CLK_GRP  = 3'd7;

  // gate-select encodings
  localparam code_t GAT_ON   = 3'd0;
  localparam code_t GAT_OFF  = 3'd1;
  localparam code_t GAT_PIN  = 3'd2;
  localparam code_t GAT_INV  = 3'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic                clkWr;
    logic                gatWr;
    logic [CH_IDX_W-1:0] chan;
    code_t               code;
  } cfgStrobe_t;

endpackage

// File: rtl/ctr_route_sync.sv
module ctr_route_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  logic [STAGES-1:0][W-1:0] pipe;
  logic [W-1:0]             last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
      last <= '0;
    end else begin
      pipe[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      last <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~last;

  for (genvar w = 0; w < W; w++) begin : g_chk
    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      rise[w] |=> !rise[w]);
  end

endmodule

// File: rtl/ctr_route_timebase.sv
module ctr_route_timebase
  import ctr_route_pkg::*;
#(
  parameter int DIV = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  output logic [TB_STAGES-1:0] strobe
);

  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  assign strobe[0] = tick;

  for (genvar k = 1; k < TB_STAGES; k++) begin : g_stage
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
      end else if (strobe[k-1]) begin
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
    end

    assign strobe[k] = strobe[k-1] && (cnt == LAST);
  end

endmodule

// File: rtl/ctr_route_ctrl.sv
module ctr_route_ctrl
  import ctr_route_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int ADDR_W = 4
) (
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  code_t               wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  code_t [NCH-1:0]     clkCode,
  input  code_t [NCH-1:0]     gatCode,
  output cfgStrobe_t          cfg,
  output code_t               rdData
);

  localparam int CH_W = ADDR_W - 1;

  logic [CH_W-1:0] wrCh;
  logic [CH_W-1:0] rdCh;
  logic            wrOk;
  logic            rdOk;

  assign wrCh = wrAddr[ADDR_W-1:1];
  assign rdCh = rdAddr[ADDR_W-1:1];
  assign wrOk = (32'(wrCh) < NCH);
  assign rdOk = (32'(rdCh) < NCH);

  always_comb begin
    cfg = '0;
    if (wrEn && wrOk) begin
      cfg.chan  = CH_IDX_W'(wrCh);
      cfg.code  = wrData;
      cfg.gatWr = wrAddr[0];
      cfg.clkWr = !wrAddr[0];
    end
  end

  always_comb begin
    rdData = '0;
    if (rdOk) begin
      rdData = rdAddr[0] ? gatCode[rdCh] : clkCode[rdCh];
    end
  end

endmodule

// File: rtl/ctr_route_datapath.sv
module ctr_route_datapath
  import ctr_route_pkg::*;
#(
  parameter int NUM_GROUPS  = 2,
  parameter int DIV         = 10,
  parameter int SYNC_STAGES = 2,
  localparam int NCH        = GRP_SIZE * NUM_GROUPS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  cfgStrobe_t            cfg,
  input  logic                  tbTick,
  input  logic [NCH-1:0]        clkPin,
  input  logic [NCH-1:0]        gatPin,
  input  logic [NUM_GROUPS-1:0] grpClk,
  input  logic [NCH-1:0]        ctrOut,
  output code_t [NCH-1:0]       clkCode,
  output code_t [NCH-1:0]       gatCode,
  output logic [NCH-1:0]        clkEn,
  output logic [NCH-1:0]        gateLvl,
  output logic [NCH-1:0]        clkPinOe,
  output logic [NCH-1:0]        gatPinOe
);

  logic [TB_STAGES-1:0]  tbStr;
  logic [NCH-1:0]        pinRise;
  logic [NCH-1:0]        pinLvlUnused;
  logic [NCH-1:0]        gatLvlSync;
  logic [NCH-1:0]        gatRiseUnused;
  logic [NUM_GROUPS-1:0] grpRise;
  logic [NUM_GROUPS-1:0] grpLvlUnused;
  logic [NCH-1:0]        outPrev;
  logic [NCH-1:0]        outRise;

  ctr_route_timebase #(.DIV(DIV)) u_tb (
    .clk(clk), .rst(rst), .tick(tbTick), .strobe(tbStr)
  );

  ctr_route_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_clkSync (
    .clk(clk), .rst(rst), .din(clkPin), .lvl(pinLvlUnused), .rise(pinRise)
  );

  ctr_route_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_gatSync (
    .clk(clk), .rst(rst), .din(gatPin), .lvl(gatLvlSync), .rise(gatRiseUnused)
  );

  ctr_route_sync #(.W(NUM_GROUPS), .STAGES(SYNC_STAGES)) u_grpSync (
    .clk(clk), .rst(rst), .din(grpClk), .lvl(grpLvlUnused), .rise(grpRise)
  );

  always_ff @(posedge clk) begin
    if (rst) outPrev <= '0;
    else     outPrev <= ctrOut;
  end
  assign outRise = ctrOut & ~outPrev;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int GRP   = i / GRP_SIZE;
    localparam int PREV1 = (i + NCH - 1) % NCH;  // preceding channel along the ring
    localparam int PREV2 = (i + NCH - 2) % NCH;  // two places back along the ring

    logic selClk;
    logic selGate;

    always_ff @(posedge clk) begin
      if (rst) begin
        clkCode[i] <= CLK_PIN;
        gatCode[i] <= GAT_PIN;
      end else begin
        if (cfg.clkWr && cfg.chan == CH_IDX_W'(i)) clkCode[i] <= cfg.code;
        if (cfg.gatWr && cfg.chan == CH_IDX_W'(i)) gatCode[i] <= cfg.code;
      end
    end

    always_comb begin
      case (clkCode[i])
        CLK_PIN:  selClk = pinRise[i];
        CLK_PREV: selClk = outRise[PREV1];
        CLK_GRP:  selClk = grpRise[GRP];
        default:  selClk = tbStr[clkCode[i] - 3'd1];
      endcase
    end

    always_comb begin
      case (gatCode[i])
        GAT_ON:  selGate = 1'b1;
        GAT_OFF: selGate = 1'b0;
        GAT_PIN: selGate = gatLvlSync[i];
        GAT_INV: selGate = ~ctrOut[PREV2];
        default: selGate = 1'b0;
      endcase
    end

    assign clkEn[i]    = selClk;
    assign gateLvl[i]  = selGate;
    assign clkPinOe[i] = (clkCode[i] != CLK_PIN);
    assign gatPinOe[i] = (gatCode[i] != GAT_PIN);

    // R3
    clk_dir_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg.clkWr && cfg.chan == CH_IDX_W'(i)) |=> (clkPinOe[i] == ($past(cfg.code) != CLK_PIN)));

    // R3
    gat_dir_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg.gatWr && cfg.chan == CH_IDX_W'(i)) |=> (gatPinOe[i] == ($past(cfg.code) != GAT_PIN)));

    // R8
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
      (gatCode[i] == GAT_OFF) |-> !gateLvl[i]);

    // R6
    prev_clk_chk: assert property (@(posedge clk) disable iff (rst)
      (clkCode[i] == CLK_PREV && outRise[PREV1]) |-> clkEn[i]);
  end

endmodule

// File: rtl/ctr_route.sv
module ctr_route
  import ctr_route_pkg::*;
#(
  parameter int NUM_GROUPS  = 2,
  parameter int DIV         = 10,
  parameter int SYNC_STAGES = 2,
  localparam int NCH        = GRP_SIZE * NUM_GROUPS,
  localparam int ADDR_W     = $clog2(NCH) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tbTick,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [CODE_W-1:0]     wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [CODE_W-1:0]     rdData,
  input  logic [NCH-1:0]        clkPin,
  input  logic [NCH-1:0]        gatPin,
  input  logic [NUM_GROUPS-1:0] grpClk,
  input  logic [NCH-1:0]        ctrOut,
  output logic [NCH-1:0]        clkEn,
  output logic [NCH-1:0]        gateLvl,
  output logic [NCH-1:0]        clkPinOe,
  output logic [NCH-1:0]        gatPinOe
);

  cfgStrobe_t       cfg;
  code_t [NCH-1:0]  clkCode;
  code_t [NCH-1:0]  gatCode;

  ctr_route_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .clkCode(clkCode), .gatCode(gatCode), .cfg(cfg), .rdData(rdData)
  );

  ctr_route_datapath #(
    .NUM_GROUPS(NUM_GROUPS), .DIV(DIV), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst(rst), .cfg(cfg), .tbTick(tbTick),
    .clkPin(clkPin), .gatPin(gatPin), .grpClk(grpClk), .ctrOut(ctrOut),
    .clkCode(clkCode), .gatCode(gatCode), .clkEn(clkEn), .gateLvl(gateLvl),
    .clkPinOe(clkPinOe), .gatPinOe(gatPinOe)
  );

endmodule

// File: tb/ctr_route_bench.sv
`timescale 1ns/1ps
module ctr_route_bench;

  localparam int NCH = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tbTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [2:0] wrData = '0;
  logic [3:0] rdAddr = '0;
  logic [2:0] rdData;
  logic [5:0] clkPin = '0;
  logic [5:0] gatPin = '0;
  logic [1:0] grpClk = '0;
  logic [5:0] ctrOut = '0;
  logic [5:0] clkEn;
  logic [5:0] gateLvl;
  logic [5:0] clkPinOe;
  logic [5:0] gatPinOe;

  always #4 clk = ~clk;

  ctr_route u_ctr_route (
    .clk(clk), .rst(rst), .tbTick(tbTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .clkPin(clkPin),
    .gatPin(gatPin), .grpClk(grpClk), .ctrOut(ctrOut), .clkEn(clkEn),
    .gateLvl(gateLvl), .clkPinOe(clkPinOe), .gatPinOe(gatPinOe)
  );

  // scoreboard
  typedef struct { string tag; int exp; } expItem_t;
  expItem_t expQ[$];
  int       obsQ[$];
  int       total = 0;
  int       bad = 0;
  bit       done = 1'b0;

  task automatic check(string tag, int got, int exp);
    expItem_t e;
    e.tag = tag;
    e.exp = exp;
    expQ.push_back(e);
    obsQ.push_back(got);
  endtask

  initial begin : monitor
    forever begin
      expItem_t e;
      int got;
      wait (obsQ.size() > 0 && expQ.size() > 0);
      e   = expQ.pop_front();
      got = obsQ.pop_front();
      total++;
      if (got != e.exp) begin
        bad++;
        $display("FAIL %s: got %0d expected %0d", e.tag, got, e.exp);
      end
    end
  end

  // pulse counters sampled away from the active edge
  int pulseCnt [NCH];
  initial for (int i = 0; i < NCH; i++) pulseCnt[i] = 0;
  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) if (clkEn[i]) pulseCnt[i]++;
  end

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wrReg(int ch, bit isGate, int code);
    wrEn   = 1'b1;
    wrAddr = {3'(ch), isGate};
    wrData = 3'(code);
    step();
    wrEn   = 1'b0;
  endtask

  task automatic rdReg(int ch, bit isGate, output int val);
    rdAddr = {3'(ch), isGate};
    #1;
    val = int'(rdData);
  endtask

  task automatic sampleGate(output int val);
    @(negedge clk);
    val = int'(gateLvl);
    step();
  endtask

  initial begin : driver
    int v;
    int base [NCH];

    step(3);
    rst = 1'b0;
    step();

    // R1 reset state
    @(negedge clk);
    check("R1 clkPinOe", int'(clkPinOe), 0);
    check("R1 gatPinOe", int'(gatPinOe), 0);
    check("R1 clkEn", int'(clkEn), 0);
    step();
    rdReg(0, 0, v); check("R1 ch0 clock code", v, 0);
    rdReg(5, 1, v); check("R1 ch5 gate code", v, 2);

    // R2 write and read-back, reserved gate code kept
    wrReg(0, 0, 5);
    wrReg(0, 1, 6);
    rdReg(0, 0, v); check("R2 ch0 clock code", v, 5);
    rdReg(0, 1, v); check("R2 ch0 reserved gate code", v, 6);
    // R3 directions follow the codes
    @(negedge clk);
    check("R3 clkPinOe after clock code 5", int'(clkPinOe), 1);
    check("R3 gatPinOe after gate code 6", int'(gatPinOe), 1);
    step();
    // R2 out-of-range channel 7 ignored
    wrReg(7, 0, 3);
    wrReg(7, 1, 3);
    rdReg(7, 0, v); check("R2 absent channel reads 0", v, 0);
    @(negedge clk);
    check("R2 clkPinOe unchanged by absent channel", int'(clkPinOe), 1);
    check("R2 gatPinOe unchanged by absent channel", int'(gatPinOe), 1);
    step();
    wrReg(0, 1, 2);
    wrReg(0, 0, 0);
    @(negedge clk);
    check("R3 clkPinOe back to input", int'(clkPinOe), 0);
    check("R3 gatPinOe back to input", int'(gatPinOe), 0);
    step();

    // R8 constant and reserved gates, pin held high
    gatPin[1] = 1'b1;
    step(4);
    wrReg(1, 1, 0);
    sampleGate(v); check("R8 gate code 0 enables", (v >> 1) & 1, 1);
    wrReg(1, 1, 1);
    sampleGate(v); check("R8 gate code 1 disables", (v >> 1) & 1, 0);
    wrReg(1, 1, 5);
    sampleGate(v); check("R8 reserved gate code 5 disables", (v >> 1) & 1, 0);

    // R9 gate from pin with two sampling stages
    wrReg(1, 1, 2);
    sampleGate(v); check("R9 gate follows high pin", (v >> 1) & 1, 1);
    gatPin[1] = 1'b0;
    step();
    @(negedge clk); check("R9 gate one edge after pin fall", (int'(gateLvl) >> 1) & 1, 1);
    step();
    @(negedge clk); check("R9 gate two edges after pin fall", (int'(gateLvl) >> 1) & 1, 0);
    step();

    // R4 pin clock pulses on ch1
    base[1] = pulseCnt[1];
    for (int p = 0; p < 4; p++) begin
      clkPin[1] = 1'b1; step(3);
      clkPin[1] = 1'b0; step(3);
    end
    step(4);
    check("R4 four pin edges on ch1", pulseCnt[1] - base[1], 4);

    // R11 long high level yields one pulse
    base[1] = pulseCnt[1];
    clkPin[1] = 1'b1; step(20);
    clkPin[1] = 1'b0; step(4);
    check("R11 held pin gives one pulse", pulseCnt[1] - base[1], 1);

    // R7 shared group clock
    wrReg(0, 0, 7);
    wrReg(2, 0, 7);
    wrReg(3, 0, 7);
    for (int i = 0; i < NCH; i++) base[i] = pulseCnt[i];
    for (int p = 0; p < 3; p++) begin
      grpClk[0] = 1'b1; step(3);
      grpClk[0] = 1'b0; step(3);
    end
    step(4);
    check("R7 ch0 sees group 0 clock", pulseCnt[0] - base[0], 3);
    check("R7 ch2 sees group 0 clock", pulseCnt[2] - base[2], 3);
    check("R7 ch3 ignores group 0 clock", pulseCnt[3] - base[3], 0);
    base[3] = pulseCnt[3];
    for (int p = 0; p < 2; p++) begin
      grpClk[1] = 1'b1; step(3);
      grpClk[1] = 1'b0; step(3);
    end
    step(4);
    check("R7 ch3 sees group 1 clock", pulseCnt[3] - base[3], 2);

    // R6 previous-channel clock around the ring
    wrReg(0, 0, 6);
    wrReg(3, 0, 6);
    for (int i = 0; i < NCH; i++) base[i] = pulseCnt[i];
    for (int p = 0; p < 2; p++) begin
      ctrOut[5] = 1'b1; step(2);
      ctrOut[5] = 1'b0; step(2);
    end
    check("R6 ch0 follows ch5 across the ring", pulseCnt[0] - base[0], 2);
    check("R6 ch3 ignores ch5", pulseCnt[3] - base[3], 0);
    base[3] = pulseCnt[3];
    ctrOut[2] = 1'b1; step(2);
    ctrOut[2] = 1'b0; step(2);
    check("R6 ch3 follows ch2", pulseCnt[3] - base[3], 1);

    // R10 inverted-output gates
    wrReg(0, 1, 3);
    wrReg(2, 1, 3);
    wrReg(3, 1, 3);
    ctrOut = 6'b000000;
    sampleGate(v); check("R10 all sources low", v & 6'b001101, 6'b001101);
    ctrOut = 6'b010000;
    sampleGate(v); check("R10 ch0 gated by ch4", v & 6'b001101, 6'b001100);
    ctrOut = 6'b000001;
    sampleGate(v); check("R10 ch2 gated by ch0", v & 6'b001101, 6'b001001);
    ctrOut = 6'b000010;
    sampleGate(v); check("R10 ch3 gated by ch1", v & 6'b001101, 6'b000101);
    ctrOut = 6'b000000;

    // R5 decade timebases
    for (int i = 0; i < 5; i++) wrReg(i, 0, i + 1);
    wrReg(5, 0, 0);
    step(2);
    for (int i = 0; i < NCH; i++) base[i] = pulseCnt[i];
    tbTick = 1'b1;
    step(10000);
    tbTick = 1'b0;
    step(2);
    check("R5 code 1 rate", pulseCnt[0] - base[0], 10000);
    check("R5 code 2 rate", pulseCnt[1] - base[1], 1000);
    check("R5 code 3 rate", pulseCnt[2] - base[2], 100);
    check("R5 code 4 rate", pulseCnt[3] - base[3], 10);
    check("R5 code 5 rate", pulseCnt[4] - base[4], 1);

    wait (expQ.size() == 0);
    #1;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    #(150000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule